// File: doc/BRIEF.md
# Floating-Point Round to Signed 64-bit Integral Value

This unit takes one IEEE-754 operand, single or double precision, and rounds it to an integral value in the same floating-point format. The integral value must also be representable as a signed 64-bit integer. A control input picks the rounding direction for each operation. Along with the rounded value, the unit reports an inexact flag and an invalid flag. Any operand that cannot map into the signed 64-bit range is replaced by the float encoding of -2^63.

The result is written into the low 32 or 64 bits of a 128-bit destination word. The remaining upper bits are either copied from the previous destination value or cleared, depending on a merge enable. A format code outside the two supported precisions is reported on an undefined-operation output, and the destination word is returned unchanged.

Operations enter through a valid/ready input stream. Results leave through a valid/ready output stream that holds one registered slot. An operation is accepted on a clock edge where `in_valid` and `in_ready` are both high. Its result appears on the next cycle. `in_ready` equals `!out_valid || out_ready`. While `out_valid` is high and `out_ready` is low, the output slot and all its fields stay frozen, and no new operation is accepted.

Top module: `fr64_round_unit`

## Requirements
- R1: `in_fmt` = 00 selects single precision, with the operand taken from `in_operand[31:0]` and bits [63:32] ignored. `in_fmt` = 01 selects double precision, with the operand taken from all 64 bits.
- R2: `in_fmt` = 10 or 11 raises `out_undef`, returns `in_old_dest` unchanged as the 128-bit result, and clears both exception flags.
- R3: `in_rmode` selects the rounding direction: 00 to nearest with ties to even, 01 toward +infinity, 10 toward -infinity, 11 toward zero. Operands with magnitude of at least 1 and a fractional part round in that direction.
- R4: A zero operand of either sign returns the same signed zero, with both flags clear.
- R5: `out_inexact` is high exactly when the rounded value differs numerically from the operand and invalid is not raised.
- R6: Infinities, all NaNs, and values whose rounded result lies outside [-2^63, 2^63) return -2^63 encoded in the operand's format. That is 0xDF000000 for single and 0xC3E0000000000000 for double. `out_invalid` is set and `out_inexact` is clear.
- R7: An operand equal to exactly -2^63 is in range and passes through unchanged. Any operand of +2^63 or above is invalid.
- R8: An in-range operand whose unbiased exponent is at least the fraction width (23 for single, 52 for double) passes through unchanged, with no flags.
- R9: A nonzero operand with magnitude below 1, subnormals included, rounds to a signed zero or to ±1.0 according to the mode. A zero result keeps the operand's sign, and inexact is set.
- R10: With `in_merge` high, result bits above the lane come from `in_old_dest`. With `in_merge` low, those bits are zero.
- R11: A result appears with `out_valid` one cycle after acceptance. `in_ready` equals `!out_valid || out_ready`. While `out_valid` is high and `out_ready` is low, all output fields hold stable.
- R12: During reset `out_valid` is low and `in_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operation offered |
| in_ready | output | 1 | Unit can accept an operation |
| in_fmt | input | 2 | Format code: 00 single, 01 double, 1x undefined |
| in_rmode | input | 2 | Rounding direction code |
| in_merge | input | 1 | Keep upper destination bits when high |
| in_operand | input | 64 | Operand; single uses bits [31:0] |
| in_old_dest | input | 128 | Previous destination word |
| out_valid | output | 1 | Result slot occupied |
| out_ready | input | 1 | Consumer takes the result |
| out_result | output | 128 | Destination word with rounded lane |
| out_inexact | output | 1 | Rounded value differs from the operand |
| out_invalid | output | 1 | Operand not representable in signed 64-bit range |
| out_undef | output | 1 | Format code was undefined |

## Verification
The bench targets the rounding boundaries where designs typically break:
- Ties at 2.5 and 3.5. A design that truncates or rounds ties away from zero returns 3.0 or 3.0 where 2.0 and 4.0 are required.
- The mantissa carry at 3.5. A design that drops the carry yields 2.0 instead of 4.0.
- The sub-unity cases: 0.5, 0.75, ±0.3 and a subnormal. Here a wrong sign on the zero, or a missed ±1.0 under directed modes, shows up directly.
- The range edges at exactly ±2^63 and at the neighbours of -2^63. An off-by-one range test would either reject -2^63 or accept +2^63.

Infinity, NaN, undefined format codes, merge on and off, and a stalled output are each driven. These cases expose flags raised together, a lane leaking garbage, or a result changing while the consumer is stalled.

// File: rtl/fr64_pkg.sv
package fr64_pkg;

  typedef enum logic [1:0] {
    RM_NEAR_EVEN = 2'b00,
    RM_UP        = 2'b01,
    RM_DOWN      = 2'b10,
    RM_ZERO      = 2'b11
  } rmode_e;

  localparam int OP_W    = 64;
  localparam int DEST_W  = 128;
  localparam int SGL_W   = 32;
  localparam int NUM_FMT = 2;
  localparam int INT_W   = 64;

  function automatic int fmt_exp_w(input int idx);
    return (idx == 0) ? 8 : 11;
  endfunction

  function automatic int fmt_frac_w(input int idx);
    return (idx == 0) ? 23 : 52;
  endfunction

endpackage

// File: rtl/fr64_round_core.sv
module fr64_round_core
  import fr64_pkg::*;
#(
  parameter int EXP_W  = 8,
  parameter int FRAC_W = 23,
  parameter int INT_W  = 64
) (
  input  logic [EXP_W+FRAC_W:0] op_i,
  input  rmode_e                rmode_i,
  output logic [EXP_W+FRAC_W:0] res_o,
  output logic                  inexact_o,
  output logic                  invalid_o
);

  localparam int W    = 1 + EXP_W + FRAC_W;
  localparam int BIAS = (1 << (EXP_W - 1)) - 1;
  localparam int XW   = EXP_W + 2;
  localparam int MW   = FRAC_W + 2;

  localparam logic [XW-1:0]        BIAS_X = XW'(BIAS);
  localparam logic signed [XW-1:0] FW_S   = XW'(FRAC_W);
  localparam logic signed [XW-1:0] TOP_S  = XW'(INT_W - 1);
  localparam logic signed [XW-1:0] NEG1_S = '1;
  localparam logic [EXP_W-1:0]     ONE_E  = EXP_W'(BIAS);
  localparam logic [W-1:0]         NEG_V  = {1'b1, EXP_W'(BIAS + INT_W - 1), {FRAC_W{1'b0}}};

  logic                     sgn;
  logic [EXP_W-1:0]         ex;
  logic [FRAC_W-1:0]        fr;
  logic [XW-1:0]            unb;
  logic signed [XW-1:0]     su;
  logic [XW-1:0]            ksh;

  assign sgn = op_i[W-1];
  assign ex  = op_i[W-2:FRAC_W];
  assign fr  = op_i[FRAC_W-1:0];
  assign unb = {2'b00, ex} - BIAS_X;
  assign su  = $signed(unb);
  assign ksh = XW'(FW_S - su);

  // Fraction-bearing path: 0 <= unbiased exponent < FRAC_W
  logic [MW-1:0] mant, one_k, mask, half, kept, sum;
  logic          rnd_bit, sticky, lsb, frac_nz, mid_up, carry;

  assign mant    = {2'b01, fr};
  assign one_k   = MW'(1) << ksh;
  assign mask    = one_k - MW'(1);
  assign half    = one_k >> 1;
  assign kept    = mant & ~mask;
  assign frac_nz = |(mant & mask);
  assign rnd_bit = |(mant & half);
  assign sticky  = |(mant & (half - MW'(1)));
  assign lsb     = |(mant & one_k);

  always_comb begin
    case (rmode_i)
      RM_NEAR_EVEN: mid_up = rnd_bit && (sticky || lsb);
      RM_UP:        mid_up = frac_nz && !sgn;
      RM_DOWN:      mid_up = frac_nz && sgn;
      default:      mid_up = 1'b0;
    endcase
  end

  assign sum   = kept + (mid_up ? one_k : '0);
  assign carry = sum[MW-1];

  // Sub-unity decision
  logic tiny_up;
  always_comb begin
    case (rmode_i)
      RM_NEAR_EVEN: tiny_up = (su == NEG1_S) && (fr != '0);
      RM_UP:        tiny_up = !sgn;
      RM_DOWN:      tiny_up = sgn;
      default:      tiny_up = 1'b0;
    endcase
  end

  always_comb begin
    res_o     = op_i;
    inexact_o = 1'b0;
    invalid_o = 1'b0;
    if (ex == '1) begin
      res_o     = NEG_V;
      invalid_o = 1'b1;
    end else if (ex == '0 && fr == '0) begin
      res_o = op_i;
    end else if (su < 0) begin
      inexact_o = 1'b1;
      res_o     = tiny_up ? {sgn, ONE_E, {FRAC_W{1'b0}}} : {sgn, {(W-1){1'b0}}};
    end else if (su >= FW_S) begin
      if (su > TOP_S || (su == TOP_S && (!sgn || fr != '0))) begin
        res_o     = NEG_V;
        invalid_o = 1'b1;
      end
    end else begin
      inexact_o = frac_nz;
      res_o     = {sgn, ex + EXP_W'(carry), sum[FRAC_W-1:0]};
    end
  end

endmodule

// File: rtl/fr64_dest_merge.sv
module fr64_dest_merge #(
  parameter int DEST_W = 128,
  parameter int OP_W   = 64,
  parameter int SGL_W  = 32
) (
  input  logic              fmt_dbl_i,
  input  logic              merge_i,
  input  logic [OP_W-1:0]   lane_i,
  input  logic [DEST_W-1:0] old_i,
  output logic [DEST_W-1:0] dest_o
);

  logic [DEST_W-1:0] lane_mask;

  assign lane_mask = fmt_dbl_i ? DEST_W'({OP_W{1'b1}}) : DEST_W'({SGL_W{1'b1}});
  assign dest_o    = (DEST_W'(lane_i) & lane_mask)
                   | (old_i & ~lane_mask & {DEST_W{merge_i}});

endmodule

// File: rtl/fr64_round_unit.sv
module fr64_round_unit
  import fr64_pkg::*;
#(
  parameter int P_OP_W   = fr64_pkg::OP_W,
  parameter int P_DEST_W = fr64_pkg::DEST_W
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                in_valid,
  output logic                in_ready,
  input  logic [1:0]          in_fmt,
  input  logic [1:0]          in_rmode,
  input  logic                in_merge,
  input  logic [P_OP_W-1:0]   in_operand,
  input  logic [P_DEST_W-1:0] in_old_dest,
  output logic                out_valid,
  input  logic                out_ready,
  output logic [P_DEST_W-1:0] out_result,
  output logic                out_inexact,
  output logic                out_invalid,
  output logic                out_undef
);

  logic [P_OP_W-1:0] lane_res [NUM_FMT];
  logic              lane_inx [NUM_FMT];
  logic              lane_inv [NUM_FMT];

  for (genvar gi = 0; gi < NUM_FMT; gi++) begin : g_fmt
    localparam int EW = fmt_exp_w(gi);
    localparam int FW = fmt_frac_w(gi);
    localparam int LW = 1 + EW + FW;
    logic [LW-1:0] r;
    fr64_round_core #(.EXP_W(EW), .FRAC_W(FW), .INT_W(INT_W)) u_core (
      .op_i      (in_operand[LW-1:0]),
      .rmode_i   (rmode_e'(in_rmode)),
      .res_o     (r),
      .inexact_o (lane_inx[gi]),
      .invalid_o (lane_inv[gi])
    );
    assign lane_res[gi] = P_OP_W'(r);
  end

  logic                is_undef, sel;
  logic [P_DEST_W-1:0] merged, next_result;
  logic                accept;

  assign is_undef = in_fmt[1];
  assign sel      = in_fmt[0];

  fr64_dest_merge #(.DEST_W(P_DEST_W), .OP_W(P_OP_W), .SGL_W(SGL_W)) u_merge (
    .fmt_dbl_i (sel),
    .merge_i   (in_merge),
    .lane_i    (lane_res[sel]),
    .old_i     (in_old_dest),
    .dest_o    (merged)
  );

  assign next_result = is_undef ? in_old_dest : merged;
  assign in_ready    = !out_valid || out_ready;
  assign accept      = in_valid && in_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid   <= 1'b0;
      out_result  <= '0;
      out_inexact <= 1'b0;
      out_invalid <= 1'b0;
      out_undef   <= 1'b0;
    end else if (accept) begin
      out_valid   <= 1'b1;
      out_result  <= next_result;
      out_inexact <= !is_undef && lane_inx[sel];
      out_invalid <= !is_undef && lane_inv[sel];
      out_undef   <= is_undef;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end

  // R11: accepted operation shows up on the next cycle
  p_latency_r11: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> out_valid);

  // R11: stalled output keeps its payload
  p_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_result)
      && $stable(out_inexact) && $stable(out_invalid) && $stable(out_undef)));

  // R5/R6: invalid and inexact never raised together
  p_flag_excl_r5: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !(out_invalid && out_inexact));

  // R2: undefined format returns the old destination and no flags
  p_undef_keep_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && in_fmt[1]) |=> (out_undef && out_result == $past(in_old_dest)
      && !out_invalid && !out_inexact));

  // R10: double lane without merge clears the upper half
  p_upper_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && in_fmt == 2'b01 && !in_merge) |=> (out_result[P_DEST_W-1:P_OP_W] == '0));

endmodule

// File: tb/fr64_round_unit_tb.sv
`timescale 1ns/1ps
module fr64_round_unit_tb_top;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         in_valid = 1'b0;
  logic         in_ready;
  logic [1:0]   in_fmt = 2'b00;
  logic [1:0]   in_rmode = 2'b00;
  logic         in_merge = 1'b0;
  logic [63:0]  in_operand = '0;
  logic [127:0] in_old_dest = '0;
  logic         out_valid;
  logic         out_ready = 1'b1;
  logic [127:0] out_result;
  logic         out_inexact, out_invalid, out_undef;

  int errors = 0;
  int checks = 0;

  always #2 clk = ~clk;

  fr64_round_unit dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_fmt(in_fmt), .in_rmode(in_rmode), .in_merge(in_merge),
    .in_operand(in_operand), .in_old_dest(in_old_dest),
    .out_valid(out_valid), .out_ready(out_ready), .out_result(out_result),
    .out_inexact(out_inexact), .out_invalid(out_invalid), .out_undef(out_undef)
  );

  localparam logic [127:0] OLD_PAT = 128'hA5A5_5A5A_0123_4567_89AB_CDEF_F00D_BEEF;

  logic [127:0] cap_res;
  logic         cap_inx, cap_inv, cap_und;

  task automatic chk(input string tag, input logic [127:0] got, input logic [127:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic run_op(input logic [1:0] fmt, input logic [1:0] rm, input logic mrg,
                        input logic [63:0] op, input logic [127:0] old);
    @(negedge clk);
    in_valid = 1'b1; in_fmt = fmt; in_rmode = rm; in_merge = mrg;
    in_operand = op; in_old_dest = old;
    while (!in_ready) @(negedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    chk("R11 out_valid after one cycle", {127'd0, out_valid}, 128'd1);
    cap_res = out_result; cap_inx = out_inexact; cap_inv = out_invalid; cap_und = out_undef;
  endtask

  task automatic t_sgl(input string tag, input logic [1:0] rm, input logic [31:0] op,
                       input logic [31:0] exp, input logic ex_inx, input logic ex_inv);
    run_op(2'b00, rm, 1'b0, {32'hFFFF_FFFF, op}, OLD_PAT);
    chk({tag, " result"}, cap_res, {96'd0, exp});
    chk({tag, " flags"}, {125'd0, cap_und, cap_inv, cap_inx}, {125'd0, 1'b0, ex_inv, ex_inx});
  endtask

  task automatic t_dbl(input string tag, input logic [1:0] rm, input logic [63:0] op,
                       input logic [63:0] exp, input logic ex_inx, input logic ex_inv);
    run_op(2'b01, rm, 1'b0, op, OLD_PAT);
    chk({tag, " result"}, cap_res, {64'd0, exp});
    chk({tag, " flags"}, {125'd0, cap_und, cap_inv, cap_inx}, {125'd0, 1'b0, ex_inv, ex_inx});
  endtask

  task automatic test_reset();
    chk("R12 out_valid in reset", {127'd0, out_valid}, 128'd0);
    chk("R12 in_ready in reset", {127'd0, in_ready}, 128'd1);
  endtask

  task automatic test_modes_single();
    t_sgl("R3 2.5 nearest", 2'b00, 32'h4020_0000, 32'h4000_0000, 1, 0);
    t_sgl("R3 2.5 up", 2'b01, 32'h4020_0000, 32'h4040_0000, 1, 0);
    t_sgl("R3 2.5 down", 2'b10, 32'h4020_0000, 32'h4000_0000, 1, 0);
    t_sgl("R3 2.5 zero", 2'b11, 32'h4020_0000, 32'h4000_0000, 1, 0);
    t_sgl("R3 3.5 nearest carry", 2'b00, 32'h4060_0000, 32'h4080_0000, 1, 0);
    t_sgl("R3 -2.5 up", 2'b01, 32'hC020_0000, 32'hC000_0000, 1, 0);
    t_sgl("R3 -2.5 down", 2'b10, 32'hC020_0000, 32'hC040_0000, 1, 0);
    t_sgl("R5 5.0 exact", 2'b00, 32'h40A0_0000, 32'h40A0_0000, 0, 0);
  endtask

  task automatic test_tiny();
    t_sgl("R9 0.3 nearest", 2'b00, 32'h3E99_999A, 32'h0000_0000, 1, 0);
    t_sgl("R9 0.3 up", 2'b01, 32'h3E99_999A, 32'h3F80_0000, 1, 0);
    t_sgl("R9 -0.3 up", 2'b01, 32'hBE99_999A, 32'h8000_0000, 1, 0);
    t_sgl("R9 -0.3 down", 2'b10, 32'hBE99_999A, 32'hBF80_0000, 1, 0);
    t_sgl("R9 0.5 tie", 2'b00, 32'h3F00_0000, 32'h0000_0000, 1, 0);
    t_sgl("R9 0.75 nearest", 2'b00, 32'h3F40_0000, 32'h3F80_0000, 1, 0);
    t_sgl("R9 -subnormal zero", 2'b11, 32'h8000_0001, 32'h8000_0000, 1, 0);
  endtask

  task automatic test_zero_int();
    t_sgl("R4 -0 single", 2'b01, 32'h8000_0000, 32'h8000_0000, 0, 0);
    t_dbl("R4 +0 double", 2'b10, 64'h0, 64'h0, 0, 0);
    t_sgl("R8 2^30 single", 2'b01, 32'h4E80_0000, 32'h4E80_0000, 0, 0);
    t_dbl("R8 below 2^63 double", 2'b00, 64'h43DF_FFFF_FFFF_FFFF, 64'h43DF_FFFF_FFFF_FFFF, 0, 0);
    t_dbl("R5 1.0 double exact", 2'b00, 64'h3FF0_0000_0000_0000, 64'h3FF0_0000_0000_0000, 0, 0);
  endtask

  task automatic test_double_modes();
    t_dbl("R3 2.5 nearest double", 2'b00, 64'h4004_0000_0000_0000, 64'h4000_0000_0000_0000, 1, 0);
    t_dbl("R3 -1.5 nearest double", 2'b00, 64'hBFF8_0000_0000_0000, 64'hC000_0000_0000_0000, 1, 0);
    t_dbl("R3 2.5 up double", 2'b01, 64'h4004_0000_0000_0000, 64'h4008_0000_0000_0000, 1, 0);
  endtask

  task automatic test_invalid();
    t_sgl("R6 +inf single", 2'b00, 32'h7F80_0000, 32'hDF00_0000, 0, 1);
    t_sgl("R6 nan single", 2'b11, 32'h7FC0_0000, 32'hDF00_0000, 0, 1);
    t_dbl("R6 -inf double", 2'b00, 64'hFFF0_0000_0000_0000, 64'hC3E0_0000_0000_0000, 0, 1);
    t_sgl("R7 +2^63 single", 2'b00, 32'h5F00_0000, 32'hDF00_0000, 0, 1);
    t_sgl("R7 -2^63 single", 2'b00, 32'hDF00_0000, 32'hDF00_0000, 0, 0);
    t_sgl("R7 below -2^63 single", 2'b00, 32'hDF00_0001, 32'hDF00_0000, 0, 1);
    t_dbl("R7 +2^63 double", 2'b10, 64'h43E0_0000_0000_0000, 64'hC3E0_0000_0000_0000, 0, 1);
    t_dbl("R7 -2^63 double", 2'b01, 64'hC3E0_0000_0000_0000, 64'hC3E0_0000_0000_0000, 0, 0);
  endtask

  task automatic test_merge_undef();
    run_op(2'b00, 2'b00, 1'b1, {32'h1234_5678, 32'h4020_0000}, OLD_PAT);
    chk("R10 single merge", cap_res, {OLD_PAT[127:32], 32'h4000_0000});
    chk("R1 single ignores upper operand", {96'd0, cap_res[31:0]}, {96'd0, 32'h4000_0000});
    run_op(2'b01, 2'b00, 1'b1, 64'h4004_0000_0000_0000, OLD_PAT);
    chk("R10 double merge", cap_res, {OLD_PAT[127:64], 64'h4000_0000_0000_0000});
    run_op(2'b10, 2'b00, 1'b1, 64'h7F80_0000, OLD_PAT);
    chk("R2 fmt 10 result", cap_res, OLD_PAT);
    chk("R2 fmt 10 flags", {125'd0, cap_und, cap_inv, cap_inx}, {125'd0, 3'b100});
    run_op(2'b11, 2'b01, 1'b0, 64'h4004_0000_0000_0000, ~OLD_PAT);
    chk("R2 fmt 11 result", cap_res, ~OLD_PAT);
    chk("R2 fmt 11 flags", {125'd0, cap_und, cap_inv, cap_inx}, {125'd0, 3'b100});
  endtask

  task automatic test_backpressure();
    @(negedge clk);
    out_ready = 1'b0;
    run_op(2'b00, 2'b01, 1'b0, 64'h4020_0000, OLD_PAT);
    chk("R11 first result under stall", cap_res, {96'd0, 32'h4040_0000});
    @(negedge clk);
    in_valid = 1'b1; in_fmt = 2'b00; in_rmode = 2'b10; in_merge = 1'b0;
    in_operand = 64'hC020_0000;
    chk("R11 in_ready low while stalled", {127'd0, in_ready}, 128'd0);
    @(negedge clk);
    chk("R11 result held", out_result, {96'd0, 32'h4040_0000});
    chk("R11 valid held", {127'd0, out_valid}, 128'd1);
    out_ready = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    chk("R11 second result after release", out_result, {96'd0, 32'hC040_0000});
    chk("R11 second valid", {127'd0, out_valid}, 128'd1);
    @(negedge clk);
    chk("R11 drained", {127'd0, out_valid}, 128'd0);
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    test_reset();
    rst_n = 1'b1;
    test_modes_single();
    test_tiny();
    test_zero_int();
    test_double_modes();
    test_invalid();
    test_merge_undef();
    test_backpressure();
    finish_run();
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL R11 watchdog expired: got hang expected completion");
    finish_run();
  end

endmodule